// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of a four-wire serial bus placed in front of a small byte-wide memory. It works in SPI mode 0. The bus lines are brought into the system clock domain, and edges are found there. Because of this the serial clock may stop at any point and start again later without any loss of state. Every transfer starts with one 8-bit opcode, sent most significant bit first. Array accesses then take a two-byte address, followed by data bytes at rising addresses.

Array contents are held in an internal register array of 2K x 8. Status operations are not handled here. They go to a neighbouring status and protection block through one-cycle strobes. That block returns its flag bits, plus a write permission level. The busy bit is inserted here. A write is staged in a small buffer and only takes effect when chip select rises on a byte boundary. The buffer is then copied into the array during a modelled busy window.

Top module: `smem_cmd_if`

## Requirements
- R1: After reset `so_oe_o`, `wip_o` and all strobes are low, and every array byte reads 0x00.
- R2: SI is sampled on rising SCK while `cs_ni` is low, and SO changes on falling SCK. All fields go most significant bit first. An SCK pause of any length inside a byte changes no result.
- R3: The opcodes 0x06, 0x04 and 0x00 each give a single one-cycle pulse, on `sr_wren_o`, `sr_wrdi_o` and `sr_sflb_o` in that order. No two strobes are ever high in the same cycle.
- R4: Opcode 0x01 followed by one byte pulses `sr_wrsr_o` once, with `sr_wdata_o` equal to that byte.
- R5: Opcode 0x05 returns the byte {`sr_flags_i`[6:0], `wip_o`}. This byte is sampled again for each byte clocked out while `cs_ni` stays low.
- R6: Opcode 0x03 followed by a 16-bit address returns bytes from the low 11 address bits onward. The address increments after each byte and wraps from 0x7FF to 0x000.
- R7: Opcode 0x02 followed by an address stages data bytes at consecutive wrapping addresses. It commits only if `cs_ni` rises after a whole byte, at least one byte was sent, and `wr_en_i` is high. Staged bytes beyond BUF_BYTES (16) are dropped.
- R8: A commit pulses `write_done_o` once and holds `wip_o` high for exactly max(BUSY_CYCLES, BUF_BYTES) clocks.
- R9: While `wip_o` is high, every opcode except 0x05 is ignored: no strobe, no array access, no output.
- R10: An opcode outside the seven listed causes the rest of the selection to be ignored. SO stays undriven.
- R11: `so_oe_o` is low whenever `cs_ni` is high. It is also low outside the data phase of a read.
- R12: If `cs_ni` rises with a partial data byte during a write, the write is abandoned and nothing is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for SO (low means high impedance) |
| sr_flags_i | input | 7 | Status bits 7..1 from the status block |
| wr_en_i | input | 1 | Array write permitted (latch set and not protected) |
| sr_wren_o | output | 1 | Set-write-enable strobe |
| sr_wrdi_o | output | 1 | Clear-write-enable / clear-flag strobe |
| sr_sflb_o | output | 1 | Set-flag strobe |
| sr_wrsr_o | output | 1 | Status write strobe |
| sr_wdata_o | output | 8 | Status write data |
| wip_o | output | 1 | Write in progress |
| write_done_o | output | 1 | One-cycle pulse when a write commits |

## Verification
Two functions can fall in the same cycle: a status read that samples the busy bit, and the busy window in which the commit engine is copying staged bytes into the array. The bench triggers this by starting a status read straight after a committed write. It expects bit 0 to be set in both returned bytes. It then checks that commands sent inside the window have no effect, and that the array holds the new bytes once the window closes. The monitor also counts the exact length of the window.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam logic [7:0] OP_SET_WEL  = 8'h06;
  localparam logic [7:0] OP_SET_FLAG = 8'h00;
  localparam logic [7:0] OP_CLR_WEL  = 8'h04;
  localparam logic [7:0] OP_RD_SR    = 8'h05;
  localparam logic [7:0] OP_WR_SR    = 8'h01;
  localparam logic [7:0] OP_RD_MEM   = 8'h03;
  localparam logic [7:0] OP_WR_MEM   = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RD, ST_SR_RD, ST_SR_WR, ST_WR, ST_SKIP
  } st_e;
endpackage

// File: rtl/smem_spi_phy.sv
module smem_spi_phy #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic cs_n_o,
  output logic si_o
);
  logic [STAGES-1:0] sck_sr, cs_sr, si_sr;
  logic sck_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sr <= '0;
      cs_sr  <= '1;
      si_sr  <= '0;
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sck_sr <= {sck_sr[STAGES-2:0], sck_i};
      cs_sr  <= {cs_sr[STAGES-2:0], cs_ni};
      si_sr  <= {si_sr[STAGES-2:0], si_i};
      sck_q  <= sck_sr[STAGES-1];
      cs_q   <= cs_sr[STAGES-1];
    end
  end

  assign cs_n_o     = cs_sr[STAGES-1];
  assign si_o       = si_sr[STAGES-1];
  assign sck_rise_o = ~cs_n_o & sck_sr[STAGES-1] & ~sck_q;
  assign sck_fall_o = ~cs_n_o & ~sck_sr[STAGES-1] & sck_q;
  assign cs_fall_o  = ~cs_n_o & cs_q;
  assign cs_rise_o  = cs_n_o & ~cs_q;
endmodule

// File: rtl/smem_busy.sv
module smem_busy #(
  parameter int unsigned CYCLES = 64,
  parameter int unsigned IW     = $clog2(CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_o <= '0;
    end else if (start_i) begin
      cnt_q <= IW'(CYCLES);
      idx_o <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - IW'(1);
      idx_o <= idx_o + IW'(1);
    end
  end

  assign busy_o = (cnt_q != '0);

  assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
endmodule

// File: rtl/smem_array.sv
module smem_array #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] rows [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q <= '0;
      else if (we_i && waddr_i == AW'(g))     q <= wdata_i;
    end
    assign rows[g] = q;
  end

  assign rdata_o = rows[raddr_i];
endmodule

// File: rtl/smem_cmd_if.sv
module smem_cmd_if #(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned BUF_BYTES   = 16,
  parameter int unsigned BUSY_CYCLES = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       cs_ni,
  input  logic       si_i,
  output logic       so_o,
  output logic       so_oe_o,
  input  logic [6:0] sr_flags_i,
  input  logic       wr_en_i,
  output logic       sr_wren_o,
  output logic       sr_wrdi_o,
  output logic       sr_sflb_o,
  output logic       sr_wrsr_o,
  output logic [7:0] sr_wdata_o,
  output logic       wip_o,
  output logic       write_done_o
);
  import smem_pkg::*;

  localparam int unsigned BUSY_EFF = (BUSY_CYCLES > BUF_BYTES) ? BUSY_CYCLES : BUF_BYTES;
  localparam int unsigned BUSY_W   = $clog2(BUSY_EFF + 1);
  localparam int unsigned BUF_W    = $clog2(BUF_BYTES + 1);
  localparam int unsigned BIDX_W   = $clog2(BUF_BYTES);

  logic sck_rise, sck_fall, cs_fall, cs_rise, cs_s, si_s;

  smem_spi_phy #(.STAGES(SYNC_STAGES)) u_phy (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .si_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .cs_fall_o(cs_fall), .cs_rise_o(cs_rise),
    .cs_n_o(cs_s), .si_o(si_s)
  );

  st_e               state_q;
  logic [3:0]        bcnt_q;
  logic [6:0]        sh_q;
  logic [7:0]        sh_next;
  logic [ADDR_W-1:0] addr_q, addr_next, wbase_q;
  logic              is_rd_q;
  logic [7:0]        out_q;
  logic [2:0]        obit_q;
  logic              so_q, oe_q;
  logic [BUF_W-1:0]  nbytes_q;
  logic [7:0]        buf_q [BUF_BYTES];
  logic              buf_we;
  logic              wren_q, wrdi_q, sflb_q, wrsr_q, done_q;
  logic [7:0]        wdata_q;

  logic              busy, commit;
  logic [BUSY_W-1:0] idx;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_waddr;
  logic [7:0]        arr_wdata, arr_rdata, rd_src;

  assign sh_next   = {sh_q, si_s};
  assign addr_next = {addr_q[ADDR_W-2:0], si_s};
  assign rd_src    = (state_q == ST_SR_RD) ? {sr_flags_i, busy} : arr_rdata;

  // commit only on a whole-byte boundary with something staged
  assign commit = cs_rise && state_q == ST_WR && bcnt_q[2:0] == 3'd0 &&
                  nbytes_q != '0 && wr_en_i && !busy;

  assign buf_we = sck_rise && !cs_rise && !cs_fall && state_q == ST_WR &&
                  bcnt_q[2:0] == 3'd7 && nbytes_q < BUF_W'(BUF_BYTES);

  always_ff @(posedge clk_i) begin
    if (buf_we) buf_q[nbytes_q[BIDX_W-1:0]] <= sh_next;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bcnt_q   <= '0;
      sh_q     <= '0;
      addr_q   <= '0;
      wbase_q  <= '0;
      is_rd_q  <= 1'b0;
      out_q    <= '0;
      obit_q   <= 3'd7;
      so_q     <= 1'b0;
      oe_q     <= 1'b0;
      nbytes_q <= '0;
      wren_q   <= 1'b0;
      wrdi_q   <= 1'b0;
      sflb_q   <= 1'b0;
      wrsr_q   <= 1'b0;
      wdata_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      wren_q <= 1'b0;
      wrdi_q <= 1'b0;
      sflb_q <= 1'b0;
      wrsr_q <= 1'b0;
      done_q <= commit;
      if (cs_rise) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (cs_fall) begin
        state_q <= ST_OPC;
        bcnt_q  <= '0;
        oe_q    <= 1'b0;
      end else if (sck_rise) begin
        unique case (state_q)
          ST_OPC: begin
            sh_q   <= sh_next[6:0];
            bcnt_q <= bcnt_q + 4'd1;
            if (bcnt_q == 4'd7) begin
              bcnt_q <= '0;
              obit_q <= 3'd7;
              if (busy && sh_next != OP_RD_SR) begin
                state_q <= ST_SKIP;
              end else begin
                unique case (sh_next)
                  OP_SET_WEL:  begin wren_q <= 1'b1; state_q <= ST_SKIP; end
                  OP_CLR_WEL:  begin wrdi_q <= 1'b1; state_q <= ST_SKIP; end
                  OP_SET_FLAG: begin sflb_q <= 1'b1; state_q <= ST_SKIP; end
                  OP_RD_SR:    state_q <= ST_SR_RD;
                  OP_WR_SR:    state_q <= ST_SR_WR;
                  OP_RD_MEM:   begin is_rd_q <= 1'b1; state_q <= ST_ADDR; end
                  OP_WR_MEM:   begin is_rd_q <= 1'b0; state_q <= ST_ADDR; end
                  default:     state_q <= ST_SKIP;
                endcase
              end
            end
          end
          ST_ADDR: begin
            addr_q <= addr_next;
            bcnt_q <= bcnt_q + 4'd1;
            if (bcnt_q == 4'd15) begin
              bcnt_q <= '0;
              if (is_rd_q) begin
                state_q <= ST_RD;
              end else begin
                state_q  <= ST_WR;
                wbase_q  <= addr_next;
                nbytes_q <= '0;
              end
            end
          end
          ST_SR_WR: begin
            sh_q   <= sh_next[6:0];
            bcnt_q <= bcnt_q + 4'd1;
            if (bcnt_q == 4'd7) begin
              wrsr_q  <= 1'b1;
              wdata_q <= sh_next;
              state_q <= ST_SKIP;
            end
          end
          ST_WR: begin
            sh_q   <= sh_next[6:0];
            bcnt_q <= (bcnt_q[2:0] == 3'd7) ? 4'd0 : bcnt_q + 4'd1;
            if (buf_we) nbytes_q <= nbytes_q + BUF_W'(1);
          end
          default: ;
        endcase
      end else if (sck_fall && (state_q == ST_RD || state_q == ST_SR_RD)) begin
        oe_q   <= 1'b1;
        obit_q <= obit_q - 3'd1;
        if (obit_q == 3'd7) begin
          so_q  <= rd_src[7];
          out_q <= {rd_src[6:0], 1'b0};
          if (state_q == ST_RD) addr_q <= addr_q + ADDR_W'(1);
        end else begin
          so_q  <= out_q[7];
          out_q <= {out_q[6:0], 1'b0};
        end
      end
    end
  end

  smem_busy #(.CYCLES(BUSY_EFF), .IW(BUSY_W)) u_busy (
    .clk_i, .rst_ni, .start_i(commit), .busy_o(busy), .idx_o(idx)
  );

  assign arr_we    = busy && (idx < BUSY_W'(nbytes_q));
  assign arr_waddr = wbase_q + ADDR_W'(idx);
  assign arr_wdata = buf_q[idx[BIDX_W-1:0]];

  smem_array #(.AW(ADDR_W), .DW(8)) u_array (
    .clk_i, .rst_ni,
    .we_i(arr_we), .waddr_i(arr_waddr), .wdata_i(arr_wdata),
    .raddr_i(addr_q), .rdata_o(arr_rdata)
  );

  assign so_o         = so_q;
  assign so_oe_o      = oe_q & ~cs_ni;
  assign sr_wren_o    = wren_q;
  assign sr_wrdi_o    = wrdi_q;
  assign sr_sflb_o    = sflb_q;
  assign sr_wrsr_o    = wrsr_q;
  assign sr_wdata_o   = wdata_q;
  assign wip_o        = busy;
  assign write_done_o = done_q;

  assert_oe_off_deselect_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !oe_q);
  assert_oe_read_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (state_q == ST_RD || state_q == ST_SR_RD));
  assert_strobe_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wren_q, wrdi_q, sflb_q, wrsr_q}));
  assert_no_strobe_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !(wren_q || wrdi_q || sflb_q || wrsr_q));
  assert_done_in_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> busy);
endmodule

// File: tb/smem_cmd_if_tb_top.sv
module smem_cmd_if_tb_top;
  localparam int BUSY = 1000;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe;
  logic [6:0] flags = 7'h46;
  logic wr_en = 1'b1;
  logic wren, wrdi, sflb, wrsr, wip, done;
  logic [7:0] wdata;

  always #10 clk = ~clk;

  smem_cmd_if #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .sr_flags_i(flags), .wr_en_i(wr_en),
    .sr_wren_o(wren), .sr_wrdi_o(wrdi), .sr_sflb_o(sflb), .sr_wrsr_o(wrsr),
    .sr_wdata_o(wdata), .wip_o(wip), .write_done_o(done)
  );

  int n_chk = 0, n_bad = 0;
  int c_wren = 0, c_wrdi = 0, c_sflb = 0, c_wrsr = 0, c_done = 0, c_wip = 0;

  always @(posedge clk) begin
    if (wren) c_wren++;
    if (wrdi) c_wrdi++;
    if (sflb) c_sflb++;
    if (wrsr) c_wrsr++;
    if (done) c_done++;
    if (wip)  c_wip++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       cap = 1'b0;
  logic [7:0] mon_sh = '0;
  int         mon_n = 0;

  always @(posedge sck) begin
    if (cap) begin
      mon_sh = {mon_sh[6:0], so};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (exp_q.size() == 0) begin
          chk("unexpected byte R6", {24'd0, mon_sh}, 32'hFFFF_FFFF);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(t, {24'd0, mon_sh}, {24'd0, e});
          chk({t, " oe"}, {31'd0, so_oe}, 32'd1);
        end
      end
    end
  end

  task automatic spi_byte(input logic [7:0] b, input int pause_at = -1);
    for (int i = 7; i >= 0; i--) begin
      if (i == pause_at) repeat (500) @(negedge clk);
      si = b[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cs_on();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    cs_on(); spi_byte(op); cs_off();
  endtask

  task automatic wr_mem(input logic [15:0] a, input logic [7:0] d[$]);
    cs_on();
    spi_byte(8'h02); spi_byte(a[15:8]); spi_byte(a[7:0]);
    foreach (d[i]) spi_byte(d[i]);
    cs_off();
  endtask

  task automatic rd_expect(input logic [15:0] a, input logic [7:0] d[$], input string tag);
    cs_on();
    spi_byte(8'h03); spi_byte(a[15:8]); spi_byte(a[7:0]);
    foreach (d[i]) begin exp_q.push_back(d[i]); tag_q.push_back(tag); end
    cap = 1'b1;
    foreach (d[i]) spi_byte(8'h00);
    cap = 1'b0;
    cs_off();
    chk({tag, " drained"}, exp_q.size(), 0);
    chk("so_oe after deselect R11", {31'd0, so_oe}, 32'd0);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      if (!wip) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("reset so_oe R1", {31'd0, so_oe}, 0);
    chk("reset wip R1", {31'd0, wip}, 0);
    chk("reset strobes R1", c_wren + c_wrdi + c_sflb + c_wrsr, 0);
    rd_expect(16'h0040, '{8'h00}, "reset array R1");

    // R3 single-byte commands
    cmd(8'h06);
    chk("wren pulse R3", c_wren, 1);
    cmd(8'h04);
    chk("wrdi pulse R3", c_wrdi, 1);
    cmd(8'h00);
    chk("sflb pulse R3", c_sflb, 1);
    chk("no cross strobes R3", c_wren + c_wrdi + c_sflb + c_wrsr, 3);

    // R4 status write
    cs_on(); spi_byte(8'h01); spi_byte(8'hA5); cs_off();
    chk("wrsr pulse R4", c_wrsr, 1);
    chk("wrsr data R4", {24'd0, wdata}, 32'hA5);

    // R5 status read, idle
    cs_on(); spi_byte(8'h05);
    exp_q.push_back(8'h8C); tag_q.push_back("rdsr idle R5");
    exp_q.push_back(8'h8C); tag_q.push_back("rdsr idle repeat R5");
    cap = 1'b1; spi_byte(8'h00); spi_byte(8'h00); cap = 1'b0;
    cs_off();

    // R7 R8 write, status read during busy, commands ignored R9
    c_wip = 0; c_done = 0;
    wr_mem(16'h0010, '{8'h11, 8'h22, 8'h33});
    chk("wip after commit R8", {31'd0, wip}, 1);
    cs_on(); spi_byte(8'h05);
    exp_q.push_back(8'h8D); tag_q.push_back("rdsr busy R5");
    exp_q.push_back(8'h8D); tag_q.push_back("rdsr busy repeat R5");
    cap = 1'b1; spi_byte(8'h00); spi_byte(8'h00); cap = 1'b0;
    cs_off();
    cmd(8'h06);
    chk("wren ignored busy R9", c_wren, 1);
    cs_on(); spi_byte(8'h03); spi_byte(8'h00); spi_byte(8'h10); spi_byte(8'h00);
    chk("read ignored busy R9", {31'd0, so_oe}, 0);
    cs_off();
    wait_idle();
    chk("busy length R8", c_wip, BUSY);
    chk("done pulse R8", c_done, 1);
    rd_expect(16'h0010, '{8'h11, 8'h22, 8'h33}, "read back R6 R7");

    // R6 wrap and upper address bits
    wr_mem(16'hFFFF, '{8'hAA, 8'hBB});
    wait_idle();
    rd_expect(16'h07FF, '{8'hAA, 8'hBB}, "wrap read R6");
    rd_expect(16'h0000, '{8'hBB}, "wrap write R6");

    // R12 partial byte abandons
    cs_on(); spi_byte(8'h02); spi_byte(8'h00); spi_byte(8'h20); spi_byte(8'h5A);
    for (int i = 0; i < 4; i++) begin
      si = 1'b1; repeat (HALF) @(negedge clk); sck = 1'b1;
      repeat (HALF) @(negedge clk); sck = 1'b0;
    end
    cs_off();
    chk("no commit partial R12", {31'd0, wip}, 0);
    rd_expect(16'h0020, '{8'h00}, "partial untouched R12");

    // R7 write not permitted
    wr_en = 1'b0;
    wr_mem(16'h0030, '{8'h77});
    chk("no commit wr_en low R7", {31'd0, wip}, 0);
    wr_en = 1'b1;
    rd_expect(16'h0030, '{8'h00}, "blocked write R7");

    // R7 buffer limit
    begin
      automatic logic [7:0] d[$];
      automatic logic [7:0] e[$];
      for (int i = 0; i < 17; i++) begin
        d.push_back(8'(i + 1));
        e.push_back((i < 16) ? 8'(i + 1) : 8'h00);
      end
      wr_mem(16'h0100, d);
      wait_idle();
      rd_expect(16'h0100, e, "buffer limit R7");
    end

    // R10 unknown opcode
    cs_on(); spi_byte(8'h07); spi_byte(8'hFF); spi_byte(8'hFF);
    chk("unknown opcode no oe R10", {31'd0, so_oe}, 0);
    cs_off();
    chk("unknown opcode no strobe R10", c_wren + c_wrdi + c_sflb + c_wrsr, 4);

    // R2 paused clock mid-address
    cs_on(); spi_byte(8'h03); spi_byte(8'h00); spi_byte(8'h11, 4);
    exp_q.push_back(8'h22); tag_q.push_back("paused sck R2");
    cap = 1'b1; spi_byte(8'h00, 3); cap = 1'b0;
    cs_off();
    chk("paused drained R2", exp_q.size(), 0);

    finish_run();
  end
endmodule